// File: doc/BRIEF.md
# Sequential AXI4 Register Access Master

This block turns a one-word command (read or write flag, address, write data) into one single-beat AXI4 transaction on a master port. A host-side agent such as a driver model or a small sequencer uses it to reach memory-mapped registers. Before any bus activity the block checks the address against a configured register window. An address outside that window is refused at once, and no channel moves.

Accepted commands run their channel phases strictly in sequence. A write runs write-address, then write-data, then the write response. A read runs read-address, then read-data. Completion is a one-cycle pulse with an ok flag. For reads it also carries the returned word, which is handed over only when the slave answered OKAY.

Top module: `regAxiMaster`

## Requirements
- R1: An address `a` is inside the window when `BASE_ADDR <= a <= BASE_ADDR + WIN_SIZE` (both ends inclusive). A command outside it completes with `done`=1 and `doneOk`=0 in the cycle after acceptance, and no valid or ready output is ever raised for it.
- R2: For a write, `awvalid` rises in the cycle after acceptance with `awaddr` equal to the command address. Both hold unchanged until the cycle `awready` is sampled high, and `awvalid` is low from the following cycle on.
- R3: `wvalid` is raised only after the write-address handshake has completed. `wdata` holds the command data and stays stable until `wready` is sampled high. `wstrb` is all ones and `wlast` is 1.
- R4: After the data handshake `bready` is high until `bvalid` is seen. The write reports `doneOk`=1 only when `bresp` is 2'b00 (OKAY); any other code gives `doneOk`=0.
- R5: For a read, `arvalid` with `araddr` equal to the command address holds until `arready` is sampled high, then drops.
- R6: After the read-address handshake `rready` is high. The word on `rdata` is taken in the cycle `rvalid` is high, and `rready` is low from the next cycle.
- R7: A read reports `doneOk`=1 only when `rresp` is 2'b00. `doneRdata` carries the captured word on success and is 0 on any failed read, refused command or write.
- R8: Every transaction is a single beat: `awlen`=`arlen`=0, `awsize`=`arsize`=log2 of the data bytes (3'b010 for 32 bits), `awid`=`arid`=0.
- R9: `cmdReady` is high only while the block is idle. A `cmdValid` seen while busy is ignored and starts no later transaction.
- R10: `done` is a single-cycle pulse, high in the cycle after the final handshake (`bvalid`&`bready` or `rvalid`&`rready`).
- R11: At most one of `awvalid`, `wvalid`, `bready`, `arvalid`, `rready` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdAddr | input | ADDR_W | Command address |
| cmdWdata | input | DATA_W | Write data |
| cmdReady | output | 1 | Block idle, command taken this cycle |
| done | output | 1 | Completion pulse |
| doneOk | output | 1 | Completion succeeded |
| doneRdata | output | DATA_W | Read word (0 unless a successful read) |
| awid | output | 4 | Write ID, tied 0 |
| awaddr | output | ADDR_W | Write address |
| awlen | output | 8 | Burst length, tied 0 |
| awsize | output | 3 | Beat size |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Byte strobes, all ones |
| wlast | output | 1 | Last beat, tied 1 |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| arid | output | 4 | Read ID, tied 0 |
| araddr | output | ADDR_W | Read address |
| arlen | output | 8 | Burst length, tied 0 |
| arsize | output | 3 | Beat size |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | DATA_W | Read data |
| rresp | input | 2 | Read response |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |

## Verification
A refused command shows `done` one cycle after the accepting edge. A channel valid appears one cycle after acceptance or after the previous handshake, and `done` appears one cycle after the last handshake. The bench drives every input at the falling edge and samples at the next falling edge. Each sample therefore sees exactly one rising edge of state change, so every check lands in the cycle the result is due. Ready and response delays are varied per phase to show that each valid holds for as long as the slave stalls.

// File: rtl/regaxi_pkg.sv
package regaxi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_AW, ST_W, ST_B, ST_AR, ST_R
  } stateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture command fields
    logic reject;  // command outside window
    logic finWr;   // write response taken
    logic finRd;   // read data taken
  } ctrlStrobeT;
endpackage

// File: rtl/regaxi_dpath.sv
module regaxi_dpath
  import regaxi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h1004_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [1:0]        bresp,
  input  logic [1:0]        rresp,
  input  logic [DATA_W-1:0] rdata,
  output logic              inWin,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] wdataQ,
  output logic              okQ,
  output logic [DATA_W-1:0] rdataQ
);
  localparam logic [1:0] RESP_OKAY = 2'b00;

  // One extra bit catches addresses below the base as a borrow
  logic [ADDR_W:0] offset;
  assign offset = {1'b0, cmdAddr} - {1'b0, BASE_ADDR};
  assign inWin  = !offset[ADDR_W] && (offset[ADDR_W-1:0] <= WIN_SIZE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      okQ    <= 1'b0;
      rdataQ <= '0;
    end else begin
      if (strobe.load) begin
        addrQ  <= cmdAddr;
        wdataQ <= cmdWdata;
      end
      if (strobe.reject) begin
        okQ    <= 1'b0;
        rdataQ <= '0;
      end else if (strobe.finWr) begin
        okQ    <= (bresp == RESP_OKAY);
        rdataQ <= '0;
      end else if (strobe.finRd) begin
        okQ    <= (rresp == RESP_OKAY);
        rdataQ <= (rresp == RESP_OKAY) ? rdata : '0;
      end
    end
  end

  // R7: a completed read returns data only with an OKAY response
  a_r7_rdata_gated: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finRd && (rresp != RESP_OKAY) |=> (rdataQ == '0) && !okQ);
endmodule

// File: rtl/regaxi_ctrl.sv
module regaxi_ctrl
  import regaxi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdWrite,
  input  logic       inWin,
  input  logic       awready,
  input  logic       wready,
  input  logic       bvalid,
  input  logic       arready,
  input  logic       rvalid,
  output ctrlStrobeT strobe,
  output logic       cmdReady,
  output logic       awvalid,
  output logic       wvalid,
  output logic       bready,
  output logic       arvalid,
  output logic       rready,
  output logic       done
);
  stateT state, stateNext;
  logic  accept;

  assign cmdReady = (state == ST_IDLE);
  assign accept   = cmdValid && cmdReady;
  assign awvalid  = (state == ST_AW);
  assign wvalid   = (state == ST_W);
  assign bready   = (state == ST_B);
  assign arvalid  = (state == ST_AR);
  assign rready   = (state == ST_R);

  always_comb begin
    strobe        = '0;
    strobe.load   = accept;
    strobe.reject = accept && !inWin;
    strobe.finWr  = bready && bvalid;
    strobe.finRd  = rready && rvalid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept && inWin) stateNext = cmdWrite ? ST_AW : ST_AR;
      ST_AW:   if (awready) stateNext = ST_W;
      ST_W:    if (wready)  stateNext = ST_B;
      ST_B:    if (bvalid)  stateNext = ST_IDLE;
      ST_AR:   if (arready) stateNext = ST_R;
      ST_R:    if (rvalid)  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.reject || strobe.finWr || strobe.finRd;
    end
  end

  // R1: refused command never reaches the bus
  a_r1_reject_quiet: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && !inWin |=> done && !awvalid && !arvalid);
  // R11: one channel active at a time
  a_r11_one_phase: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({awvalid, wvalid, bready, arvalid, rready}));
  // R3: data phase follows the address handshake
  a_r3_w_after_aw: assert property (@(posedge clk) disable iff (!rstN)
    awvalid && awready |=> wvalid);
  // R6: rready falls right after data is taken
  a_r6_rready_drop: assert property (@(posedge clk) disable iff (!rstN)
    rready && rvalid |=> !rready && done);
  // R10: write completion one cycle after response handshake
  a_r10_done_after_b: assert property (@(posedge clk) disable iff (!rstN)
    bready && bvalid |=> done && !bready);
endmodule

// File: rtl/regAxiMaster.sv
module regAxiMaster
  import regaxi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h1004_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0000_1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic                cmdWrite,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [DATA_W-1:0]   cmdWdata,
  output logic                cmdReady,
  output logic                done,
  output logic                doneOk,
  output logic [DATA_W-1:0]   doneRdata,
  output logic [3:0]          awid,
  output logic [ADDR_W-1:0]   awaddr,
  output logic [7:0]          awlen,
  output logic [2:0]          awsize,
  output logic                awvalid,
  input  logic                awready,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic                wlast,
  output logic                wvalid,
  input  logic                wready,
  input  logic [1:0]          bresp,
  input  logic                bvalid,
  output logic                bready,
  output logic [3:0]          arid,
  output logic [ADDR_W-1:0]   araddr,
  output logic [7:0]          arlen,
  output logic [2:0]          arsize,
  output logic                arvalid,
  input  logic                arready,
  input  logic [DATA_W-1:0]   rdata,
  input  logic [1:0]          rresp,
  input  logic                rvalid,
  output logic                rready
);
  localparam int STRB_W = DATA_W / 8;
  localparam logic [2:0] BEAT_SIZE = 3'($clog2(STRB_W));

  ctrlStrobeT        strobe;
  logic              inWin;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  regaxi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .inWin(inWin), .awready(awready), .wready(wready), .bvalid(bvalid),
    .arready(arready), .rvalid(rvalid), .strobe(strobe),
    .cmdReady(cmdReady), .awvalid(awvalid), .wvalid(wvalid),
    .bready(bready), .arvalid(arvalid), .rready(rready), .done(done)
  );

  regaxi_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BASE_ADDR(BASE_ADDR), .WIN_SIZE(WIN_SIZE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdAddr(cmdAddr),
    .cmdWdata(cmdWdata), .bresp(bresp), .rresp(rresp), .rdata(rdata),
    .inWin(inWin), .addrQ(addrQ), .wdataQ(wdataQ),
    .okQ(doneOk), .rdataQ(doneRdata)
  );

  assign awaddr = addrQ;
  assign araddr = addrQ;
  assign wdata  = wdataQ;
  assign awid   = '0;
  assign arid   = '0;
  assign awlen  = '0;
  assign arlen  = '0;
  assign awsize = BEAT_SIZE;
  assign arsize = BEAT_SIZE;
  assign wstrb  = '1;
  assign wlast  = 1'b1;

  // R2: write address held through a stall
  a_r2_aw_hold: assert property (@(posedge clk) disable iff (!rstN)
    awvalid && !awready |=> awvalid && $stable(awaddr));
  // R3: write data held through a stall
  a_r3_w_hold: assert property (@(posedge clk) disable iff (!rstN)
    wvalid && !wready |=> wvalid && $stable(wdata));
  // R5: read address held through a stall
  a_r5_ar_hold: assert property (@(posedge clk) disable iff (!rstN)
    arvalid && !arready |=> arvalid && $stable(araddr));
  // R4: write status follows the response code
  a_r4_bresp_ok: assert property (@(posedge clk) disable iff (!rstN)
    bready && bvalid |=> doneOk == ($past(bresp) == 2'b00));
endmodule

// File: tb/regAxiMaster_tb.sv
module regAxiMaster_tb;
  localparam logic [31:0] BASE = 32'h1004_0000;
  localparam logic [31:0] WIN  = 32'h0000_1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 0, cmdWrite = 0;
  logic [31:0] cmdAddr = '0, cmdWdata = '0;
  logic cmdReady, done, doneOk;
  logic [31:0] doneRdata;
  logic [3:0] awid, arid;
  logic [31:0] awaddr, araddr, wdata;
  logic [7:0] awlen, arlen;
  logic [2:0] awsize, arsize;
  logic awvalid, wvalid, bready, arvalid, rready, wlast;
  logic [3:0] wstrb;
  logic awready = 0, wready = 0, bvalid = 0, arready = 0, rvalid = 0;
  logic [1:0] bresp = '0, rresp = '0;
  logic [31:0] rdata = '0;

  int nChecks = 0;
  int nErr = 0;

  always #4 clk = ~clk;  // 125 MHz

  regAxiMaster #(.BASE_ADDR(BASE), .WIN_SIZE(WIN)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .cmdReady(cmdReady),
    .done(done), .doneOk(doneOk), .doneRdata(doneRdata),
    .awid(awid), .awaddr(awaddr), .awlen(awlen), .awsize(awsize),
    .awvalid(awvalid), .awready(awready), .wdata(wdata), .wstrb(wstrb),
    .wlast(wlast), .wvalid(wvalid), .wready(wready), .bresp(bresp),
    .bvalid(bvalid), .bready(bready), .arid(arid), .araddr(araddr),
    .arlen(arlen), .arsize(arsize), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkIdleBus(input string tag);
    check({tag, " no valid"}, {awvalid, wvalid, bready, arvalid, rready}, 0);
  endtask

  // Write with per-phase ready delays; optionally poke a command while busy
  task automatic runWrite(input logic [31:0] addr, input logic [31:0] data,
                          input int awD, input int wD, input int bD,
                          input logic [1:0] resp, input logic expOk, input bit poke);
    @(negedge clk);
    cmdValid = 1; cmdWrite = 1; cmdAddr = addr; cmdWdata = data;
    @(negedge clk);
    cmdValid = 0;
    for (int i = 0; i <= awD; i++) begin
      check("R2 awvalid", awvalid, 1);
      check("R2 awaddr", awaddr, addr);
      check("R3 wvalid before aw done", wvalid, 0);
      check("R8 awlen/awsize/awid", {awlen, awsize, awid}, {8'd0, 3'b010, 4'd0});
      awready = (i == awD);
      @(negedge clk);
      awready = 0;
    end
    for (int i = 0; i <= wD; i++) begin
      check("R2 awvalid dropped", awvalid, 0);
      check("R3 wvalid", wvalid, 1);
      check("R3 wdata", wdata, data);
      check("R3 wstrb/wlast", {wstrb, wlast}, 5'b11111);
      check("R9 cmdReady busy", cmdReady, 0);
      if (poke && i == 0) begin cmdValid = 1; cmdWrite = 0; cmdAddr = BASE; end
      wready = (i == wD);
      @(negedge clk);
      wready = 0; cmdValid = 0;
    end
    for (int i = 0; i <= bD; i++) begin
      check("R4 bready", bready, 1);
      check("R4 wvalid dropped", wvalid, 0);
      check("R10 no early done", done, 0);
      bvalid = (i == bD); bresp = resp;
      @(negedge clk);
      bvalid = 0; bresp = 0;
    end
    check("R10 write done", done, 1);
    check("R4 write ok", doneOk, expOk);
    check("R7 write rdata zero", doneRdata, 0);
    checkIdleBus("R4 after write");
    @(negedge clk);
    check("R10 done one cycle", done, 0);
    check("R9 cmdReady idle", cmdReady, 1);
    checkIdleBus("R9 busy command ignored");
  endtask

  task automatic runRead(input logic [31:0] addr, input int arD, input int rD,
                         input logic [31:0] word, input logic [1:0] resp,
                         input logic expOk);
    @(negedge clk);
    cmdValid = 1; cmdWrite = 0; cmdAddr = addr;
    @(negedge clk);
    cmdValid = 0;
    for (int i = 0; i <= arD; i++) begin
      check("R5 arvalid", arvalid, 1);
      check("R5 araddr", araddr, addr);
      check("R6 rready before ar done", rready, 0);
      check("R8 arlen/arsize/arid", {arlen, arsize, arid}, {8'd0, 3'b010, 4'd0});
      arready = (i == arD);
      @(negedge clk);
      arready = 0;
    end
    for (int i = 0; i <= rD; i++) begin
      check("R5 arvalid dropped", arvalid, 0);
      check("R6 rready", rready, 1);
      rvalid = (i == rD); rdata = (i == rD) ? word : 32'hBAD0_BAD0; rresp = resp;
      @(negedge clk);
      rvalid = 0; rdata = 32'h5555_AAAA; rresp = 0;
    end
    check("R6 rready dropped", rready, 0);
    check("R10 read done", done, 1);
    check("R7 read ok", doneOk, expOk);
    check("R7 read data", doneRdata, expOk ? word : 32'h0);
    @(negedge clk);
    check("R10 done one cycle", done, 0);
  endtask

  task automatic runReject(input logic [31:0] addr, input logic wr);
    @(negedge clk);
    cmdValid = 1; cmdWrite = wr; cmdAddr = addr; cmdWdata = 32'h1234_5678;
    @(negedge clk);
    cmdValid = 0;
    check("R1 reject done", done, 1);
    check("R1 reject ok", doneOk, 0);
    check("R7 reject rdata", doneRdata, 0);
    checkIdleBus("R1 reject");
    @(negedge clk);
    check("R10 reject done one cycle", done, 0);
    checkIdleBus("R1 reject later");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R9 reset cmdReady", cmdReady, 1);
    check("R10 reset done", done, 0);
    checkIdleBus("R11 reset");
    runWrite(BASE + 32'h10, 32'hCAFE_0001, 0, 0, 0, 2'b00, 1'b1, 1'b0);
    runWrite(BASE + 32'h20, 32'hA5A5_5A5A, 2, 3, 1, 2'b10, 1'b0, 1'b1);
    runRead(BASE + 32'h4, 0, 0, 32'hDEAD_BEEF, 2'b00, 1'b1);
    runRead(BASE + 32'h8, 3, 2, 32'h0BAD_F00D, 2'b10, 1'b0);
    runReject(BASE - 32'h4, 1'b1);
    runReject(BASE + WIN + 32'h4, 1'b0);
    runRead(BASE + WIN, 1, 0, 32'h1357_9BDF, 2'b00, 1'b1);   // R1 upper edge inside
    runWrite(BASE, 32'h0000_0042, 1, 0, 2, 2'b00, 1'b1, 1'b0); // R1 lower edge inside
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule